// File: doc/BRIEF.md
# Second-Chance Page Frame Replacer

This block tracks which virtual pages occupy a small pool of physical frames and chooses a frame to give up when a new page must come in. Each reference carries a page number. The block reports whether that page is already resident (a hit) or missing (a fault). On a fault it names the frame that now holds the page, and it also says whether an older page had to be pushed out to make room.

Frames leave the pool in the order they were loaded, with one exception. A frame whose page has been touched again since it was loaded is spared once. Its touched flag is cleared and it rejoins the pool as the youngest frame. Order is kept with a rotating pointer over the frame array, so the first untouched frame the pointer reaches is the one evicted. While empty frames remain, a missing page is placed in the lowest-numbered empty frame and nothing is evicted. The disk transfer and the page-table update belong to the surrounding logic, which acts on the frame index and the evicted page number that the block reports.

Top module: `sc_page_replacer`

## Requirements
- R1: After reset, ref_ready is 1, done is 0 and every frame is empty, so the first reference faults into frame 0 without an eviction.
- R2: A reference to a resident page gives done=1, fault=0, evict=0 and frame_idx equal to that page's frame, in the cycle right after the accepting edge.
- R3: When a page misses and an empty frame exists, the page fills the lowest-indexed empty frame. The result is fault=1 and evict=0, with done in the cycle right after the accepting edge.
- R4: When the pool is full and the frame at the pointer has a clear touched flag, that frame is evicted. The result is fault=1, evict=1, frame_idx set to that frame and victim_page set to its old page, with done one cycle later than a hit.
- R5: During the search, each frame found with its touched flag set has the flag cleared and is passed over. Each frame passed over adds one cycle before done.
- R6: A newly loaded page starts with its touched flag clear. A hit sets the flag, so that frame is spared in the next search.
- R7: If every frame is touched, the search clears all flags and evicts the frame it started from. done comes NUM_FRAMES+1 cycles later than a hit would.
- R8: ref_ready is 0 from the accepting edge of a searching miss until the cycle in which its done is high. A request held valid during that time is taken only afterwards.
- R9: A page is never resident in more than one frame, so a page referenced again after loading always hits.
- R10: After an eviction, the next search starts at the frame following the evicted one, because the newly loaded page is the youngest.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_valid | input | 1 | A page reference is offered |
| ref_ready | output | 1 | Block can accept a reference this cycle |
| ref_page | input | PAGE_W | Page number being referenced |
| done | output | 1 | One-cycle pulse: result fields are valid |
| fault | output | 1 | Page was not resident |
| evict | output | 1 | A resident page was displaced |
| frame_idx | output | IDX_W | Frame now holding the referenced page |
| victim_page | output | PAGE_W | Page displaced, meaningful when evict is 1 |

## Verification
Hits and fills produce done in the cycle right after the edge that takes the request. A miss on a full pool produces done one cycle later, plus one cycle for each touched frame the search passes over. When the bench offers a request, it stamps the expected result with the exact cycle it is due, using an independent model of the frame queue. The monitor compares outputs only at that cycle, and it flags a done at any other time as an error. Between the accepting edge and the due cycle of a search, the monitor also requires ref_ready to stay low.

// File: rtl/sc_repl_pkg.sv
// Shared types for the second-chance page replacer.
package sc_repl_pkg;

    // Controller state: waiting for a reference, or walking the frame ring.
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } sc_state_e;

endpackage

// File: rtl/sc_frame_store.sv
// Frame table: page number, resident flag and touched flag per frame.
// Assumes at most one of write, clear or set targets a frame per cycle;
// write wins over clear, clear over set. Lookup is fully parallel.
module sc_frame_store #(
    parameter int NUM_FRAMES = 3,
    parameter int PAGE_W     = 20,
    parameter int IDX_W      = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [PAGE_W-1:0]     wr_page,
    input  logic                  set_en,
    input  logic [IDX_W-1:0]      set_idx,
    input  logic                  clr_en,
    input  logic [IDX_W-1:0]      clr_idx,
    input  logic [PAGE_W-1:0]     look_page,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [NUM_FRAMES-1:0] match_vec,
    output logic [PAGE_W-1:0]     rd_page,
    output logic                  rd_ref
);

    logic [NUM_FRAMES-1:0] valid_vec;
    logic [NUM_FRAMES-1:0] ref_vec;
    logic [PAGE_W-1:0]     page_arr [NUM_FRAMES];

    for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
        logic              vld_q;
        logic              tch_q;
        logic [PAGE_W-1:0] pg_q;

        // Per-frame state update: load, clear touched, or mark touched.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q <= 1'b0;
                tch_q <= 1'b0;
                pg_q  <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                vld_q <= 1'b1;
                tch_q <= 1'b0;
                pg_q  <= wr_page;
            end else if (clr_en && clr_idx == IDX_W'(g)) begin
                tch_q <= 1'b0;
            end else if (set_en && set_idx == IDX_W'(g)) begin
                tch_q <= 1'b1;
            end
        end

        assign valid_vec[g] = vld_q;
        assign ref_vec[g]   = tch_q;
        assign page_arr[g]  = pg_q;
        assign match_vec[g] = vld_q && (pg_q == look_page);
    end

    // Read port for the frame under the ring pointer.
    always_comb begin
        rd_page = page_arr[rd_idx];
        rd_ref  = ref_vec[rd_idx];
    end

    // A touched flag is only ever set on a frame that holds a page (R6).
    p_set_resident_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> valid_vec[set_idx]);

    // A search never writes over a frame still marked touched (R5).
    p_no_touched_evict_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && valid_vec[wr_idx]) |-> !ref_vec[wr_idx]);

endmodule

// File: rtl/sc_onehot_idx.sv
// Converts a one-hot (or empty) vector to a binary index plus an any flag.
// Assumes at most one bit set; with several set the index is their OR.
module sc_onehot_idx #(
    parameter int N     = 3,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     onehot,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    // OR together the indices of all set bits.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (onehot[i]) idx = idx | IDX_W'(i);
        end
        any = |onehot;
    end

endmodule

// File: rtl/sc_page_replacer.sv
// Second-chance frame replacer. Accepts one page reference at a time,
// answers hits and fills immediately, and walks a ring pointer for
// misses on a full pool, sparing touched frames once each.
// Assumes the caller holds ref_page stable while ref_valid is high.
module sc_page_replacer
    import sc_repl_pkg::*;
#(
    parameter int NUM_FRAMES = 3,
    parameter int PAGE_W     = 20
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        ref_valid,
    output logic                                        ref_ready,
    input  logic [PAGE_W-1:0]                           ref_page,
    output logic                                        done,
    output logic                                        fault,
    output logic                                        evict,
    output logic [((NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1)-1:0] frame_idx,
    output logic [PAGE_W-1:0]                           victim_page
);

    localparam int IDX_W  = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1;
    localparam int FILL_W = $clog2(NUM_FRAMES + 1);
    localparam int SCAN_W = $clog2(NUM_FRAMES + 2);
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NUM_FRAMES - 1);
    localparam logic [FILL_W-1:0] FULL_CNT = FILL_W'(NUM_FRAMES);

    sc_state_e           state_q;
    logic [IDX_W-1:0]    hand_q;
    logic [IDX_W-1:0]    hand_nxt;
    logic [FILL_W-1:0]   fill_q;
    logic [SCAN_W-1:0]   scan_q;
    logic [PAGE_W-1:0]   pend_q;

    logic [NUM_FRAMES-1:0] match_vec;
    logic [IDX_W-1:0]      hit_idx;
    logic                  hit;
    logic [PAGE_W-1:0]     rd_page;
    logic                  rd_ref;
    logic                  accept;
    logic                  full;
    logic                  wr_en;
    logic [IDX_W-1:0]      wr_idx;
    logic [PAGE_W-1:0]     wr_page;
    logic                  set_en;
    logic                  clr_en;

    sc_frame_store #(
        .NUM_FRAMES (NUM_FRAMES),
        .PAGE_W     (PAGE_W),
        .IDX_W      (IDX_W)
    ) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_page   (wr_page),
        .set_en    (set_en),
        .set_idx   (hit_idx),
        .clr_en    (clr_en),
        .clr_idx   (hand_q),
        .look_page (ref_page),
        .rd_idx    (hand_q),
        .match_vec (match_vec),
        .rd_page   (rd_page),
        .rd_ref    (rd_ref)
    );

    sc_onehot_idx #(
        .N     (NUM_FRAMES),
        .IDX_W (IDX_W)
    ) i_hit_enc (
        .onehot (match_vec),
        .idx    (hit_idx),
        .any    (hit)
    );

    assign ref_ready = (state_q == ST_IDLE);
    assign accept    = ref_valid && ref_ready;
    assign full      = (fill_q == FULL_CNT);
    assign hand_nxt  = (hand_q == LAST_IDX) ? '0 : hand_q + 1'b1;

    // Frame table commands for this cycle: mark, fill, spare or replace.
    always_comb begin
        set_en  = accept && hit;
        clr_en  = (state_q == ST_SCAN) && rd_ref;
        wr_en   = 1'b0;
        wr_idx  = hand_q;
        wr_page = pend_q;
        if (accept && !hit && !full) begin
            wr_en   = 1'b1;
            wr_idx  = fill_q[IDX_W-1:0];
            wr_page = ref_page;
        end else if ((state_q == ST_SCAN) && !rd_ref) begin
            wr_en   = 1'b1;
        end
    end

    // Controller: classify references, walk the ring, register results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            hand_q      <= '0;
            fill_q      <= '0;
            scan_q      <= '0;
            pend_q      <= '0;
            done        <= 1'b0;
            fault       <= 1'b0;
            evict       <= 1'b0;
            frame_idx   <= '0;
            victim_page <= '0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (hit) begin
                            done      <= 1'b1;
                            fault     <= 1'b0;
                            evict     <= 1'b0;
                            frame_idx <= hit_idx;
                        end else if (!full) begin
                            done      <= 1'b1;
                            fault     <= 1'b1;
                            evict     <= 1'b0;
                            frame_idx <= fill_q[IDX_W-1:0];
                            fill_q    <= fill_q + 1'b1;
                        end else begin
                            pend_q  <= ref_page;
                            scan_q  <= '0;
                            state_q <= ST_SCAN;
                        end
                    end
                end
                ST_SCAN: begin
                    hand_q <= hand_nxt;
                    if (rd_ref) begin
                        scan_q <= scan_q + 1'b1;
                    end else begin
                        done        <= 1'b1;
                        fault       <= 1'b1;
                        evict       <= 1'b1;
                        frame_idx   <= hand_q;
                        victim_page <= rd_page;
                        state_q     <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // No page can match two frames at once (R9).
    p_unique_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

    // A hit result never carries an eviction (R2).
    p_hit_no_evict_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault) |-> !evict);

    // The search passes over at most every frame once before evicting (R7).
    p_scan_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN) |-> (scan_q <= SCAN_W'(NUM_FRAMES)));

    // A search either continues or finishes with a result (R8).
    p_scan_ends_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN) |=> ((state_q == ST_SCAN) || (done && evict)));

    // Evictions only happen once the pool is full (R3).
    p_evict_when_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && evict) |-> full);

endmodule

// File: tb/test_sc_page_replacer.sv
`timescale 1ns/1ps
module test_sc_page_replacer;

    localparam int NF  = 3;
    localparam int PW  = 20;
    localparam int IW  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_valid = 1'b0;
    logic          ref_ready;
    logic [PW-1:0] ref_page = '0;
    logic          done;
    logic          fault;
    logic          evict;
    logic [IW-1:0] frame_idx;
    logic [PW-1:0] victim_page;

    sc_page_replacer #(.NUM_FRAMES(NF), .PAGE_W(PW)) i_sc_page_replacer (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_valid   (ref_valid),
        .ref_ready   (ref_ready),
        .ref_page    (ref_page),
        .done        (done),
        .fault       (fault),
        .evict       (evict),
        .frame_idx   (frame_idx),
        .victim_page (victim_page)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    int n_total = 0;
    int n_fail = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Independent model of the frame ring.
    int  m_page [NF];
    bit  m_tch  [NF];
    int  m_fill = 0;
    int  m_hand = 0;

    // Scoreboard queues, one element per outstanding reference.
    int    q_acc [$];
    int    q_due [$];
    int    q_flt [$];
    int    q_evc [$];
    int    q_frm [$];
    int    q_vic [$];
    string q_tag [$];

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    endtask

    // Driver: offer a page, compute its result from the model, queue it.
    task automatic do_ref(input int pg, input string tag_in);
        int hit_at;
        int lat;
        int flt;
        int evc;
        int frm;
        int vic;
        int skips;
        string tag;
        ref_valid = 1'b1;
        ref_page  = PW'(pg);
        while (!ref_ready) @(negedge clk);
        hit_at = -1;
        for (int i = 0; i < m_fill; i++) if (m_page[i] == pg) hit_at = i;
        vic = 0;
        skips = 0;
        if (hit_at >= 0) begin
            m_tch[hit_at] = 1;
            lat = 0; flt = 0; evc = 0; frm = hit_at; tag = "R2";
        end else if (m_fill < NF) begin
            m_page[m_fill] = pg;
            m_tch[m_fill]  = 0;
            lat = 0; flt = 1; evc = 0; frm = m_fill; tag = "R3";
            m_fill++;
        end else begin
            while (m_tch[m_hand]) begin
                m_tch[m_hand] = 0;
                m_hand = (m_hand + 1) % NF;
                skips++;
            end
            vic = m_page[m_hand];
            m_page[m_hand] = pg;
            m_tch[m_hand]  = 0;
            frm = m_hand;
            m_hand = (m_hand + 1) % NF;
            lat = 1 + skips; flt = 1; evc = 1;
            tag = (skips == 0) ? "R4" : ((skips == NF) ? "R7" : "R5");
        end
        if (tag_in != "") tag = tag_in;
        q_acc.push_back(cyc + 1);
        q_due.push_back(cyc + 1 + lat);
        q_flt.push_back(flt);
        q_evc.push_back(evc);
        q_frm.push_back(frm);
        q_vic.push_back(vic);
        q_tag.push_back(tag);
        @(posedge clk);
        @(negedge clk);
        ref_valid = 1'b0;
    endtask

    // Monitor: compare results exactly in their due cycle.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (q_due.size() != 0 && cyc >= q_acc[0] && cyc < q_due[0]) begin
                chk("R8", "ref_ready during search", int'(ref_ready), 0);
            end
            if (q_due.size() != 0 && cyc == q_due[0]) begin
                chk(q_tag[0], "done", int'(done), 1);
                chk(q_tag[0], "fault", int'(fault), q_flt[0]);
                chk(q_tag[0], "evict", int'(evict), q_evc[0]);
                chk(q_tag[0], "frame_idx", int'(frame_idx), q_frm[0]);
                if (q_evc[0] != 0) chk(q_tag[0], "victim_page", int'(victim_page), q_vic[0]);
                void'(q_acc.pop_front());
                void'(q_due.pop_front());
                void'(q_flt.pop_front());
                void'(q_evc.pop_front());
                void'(q_frm.pop_front());
                void'(q_vic.pop_front());
                void'(q_tag.pop_front());
            end else if (done) begin
                chk("R8", "unexpected done", 1, 0);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        if (cyc > 100000 && !finished) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    int lfsr = 32'h1d2c3b4a;

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ref_ready after reset", int'(ref_ready), 1);
        chk("R1", "done after reset", int'(done), 0);

        // Fill the empty pool; first reference lands in frame 0.
        do_ref('h0a11c, "R1");
        do_ref('h0b22d, "R3");
        do_ref('h0c33e, "R3");
        // Touch frame 0, so the next miss spares it and evicts frame 1.
        do_ref('h0a11c, "R2");
        do_ref('h0d44f, "R6");
        // Search resumes after the evicted frame: frame 2 goes next.
        do_ref('h0e550, "R10");
        // Re-referencing resident pages hits, one copy each.
        do_ref('h0a11c, "R9");
        do_ref('h0d44f, "R9");
        do_ref('h0e550, "R2");
        // Every frame touched: full lap before eviction.
        do_ref('h0f661, "R7");
        // Back-to-back miss with clear flags.
        do_ref('h01772, "R4");

        // Mixed stream over a small page set.
        for (int n = 0; n < 400; n++) begin
            lfsr = lfsr * 1103515245 + 12345;
            do_ref('h00400 + ((lfsr >>> 16) & 32'h7fff) % 5, "");
        end

        for (int w = 0; w < 20 && q_due.size() != 0; w++) @(negedge clk);
        repeat (4) @(negedge clk);
        chk("R8", "results left outstanding", q_due.size(), 0);
        finish_run();
    end

endmodule